// File: doc/BRIEF.md
# CPU Clock Source Selection Controller

This block picks which of three oscillators drives the CPU clock. The three sources are an internal high-speed oscillator, a main oscillator and a sub oscillator. The main and sub oscillators can each run from a crystal or take an external clock input. Software configures the block through a small byte-wide write port. The port reaches three registers: a mode register that accepts a single write after reset, an oscillator run/stop register, and a source-select register. Two stabilization-done flags come in from the oscillation-stabilization counters, which sit outside this block.

A request to change source takes effect only when the requested oscillator is enabled in the mode register, its stop bit is clear and, where needed, its stabilization flag is high. Until then the request stays pending and the current source keeps running. Status outputs give the source that is actually active, so software can poll for completion. The block also refuses to stop the oscillator that feeds the CPU. Its outputs drive a glitch-free clock multiplexer and the oscillator configuration pins.

Top module: `clksel_ctrl`

## Requirements
- R1: After a synchronous reset the active source is the internal oscillator, with cpu_src_o = 0 and src_onehot_o = 3'b001. Both stop outputs are 1, the select requests are 0, all mode fields are 0, mode_locked_o is 0 and switch_pending_o is 0.
- R2: The first full-byte write to the mode register (address 0) is stored and sets mode_locked_o. Every later write to address 0 leaves all mode fields unchanged.
- R3: A write to address 0 with bus_full_wr = 0 changes no mode field and does not set mode_locked_o.
- R4: The mode byte is laid out as follows: bit 0 main external input, bit 1 main oscillator select, bit 2 main gain (1 for a crystal above 10 MHz up to 20 MHz), bit 3 sub external input, bit 4 sub oscillator select, bits 6:5 sub drive. Each field appears on its own output.
- R5: Address 2 bit 0 requests the main source. In crystal mode (bit 0 of the mode byte = 0) the switch needs main select = 1, main stop = 0 and main_stable_i = 1. The active source changes at the first clock edge after the select write at which these conditions hold.
- R6: With the main external input set, the main source is selected without waiting for main_stable_i.
- R7: Address 2 bit 1 requests the sub source. The switch needs sub select = 1, sub stop = 0 and sub_stable_i = 1, in both crystal and external-input mode.
- R8: While the requested source is not ready, the active source is unchanged and switch_pending_o is 1.
- R9: The sub request has priority over the main request. With both request bits clear the internal oscillator is taken at the next edge, with no wait.
- R10: Address 1 holds the stop bits (bit 0 main, bit 1 sub). A write that would set the stop bit of the active source, or of the source being switched to on that edge, leaves that bit 0. The other bit of the same write still takes effect.
- R11: cpu_src_o encodes the active source as 0 internal, 1 main and 2 sub. src_onehot_o has bit i set for code i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_full_wr | input | 1 | Write covers the whole byte |
| main_stable_i | input | 1 | Main oscillator stabilization done |
| sub_stable_i | input | 1 | Sub oscillator stabilization done |
| cpu_src_o | output | 2 | Active source code |
| src_onehot_o | output | 3 | Active source, one-hot |
| switch_pending_o | output | 1 | Requested source not yet active |
| mode_locked_o | output | 1 | Mode register already written |
| main_ext_o | output | 1 | Main external input mode |
| main_osc_sel_o | output | 1 | Main oscillator select |
| main_gain_o | output | 1 | Main high-gain range |
| sub_ext_o | output | 1 | Sub external input mode |
| sub_osc_sel_o | output | 1 | Sub oscillator select |
| sub_drive_o | output | 2 | Sub oscillator drive |
| main_stop_o | output | 1 | Main oscillator stopped |
| sub_stop_o | output | 1 | Sub oscillator stopped |

## Verification
A register write is visible on the register outputs one edge after the write cycle. A source switch that the write makes possible appears on cpu_src_o one edge later still. A rising stabilization flag moves the source at the very next edge. The bench drives every input at the falling edge and samples at the falling edge after the edge where each result is due. It sweeps all mode, stop, stabilization and request combinations, letting each one settle for three cycles. Directed sequences then check the exact one-edge switch latency, the rejected stop writes and the write-once behaviour.

// File: rtl/clksel_pkg.sv
// Package: shared encodings and register layout for the clock source selector.
// Assumes a byte-or-wider write port and exactly three clock sources.
package clksel_pkg;

    localparam int NUM_SRC = 3;
    localparam int SRC_W   = 2;

    // Source codes; the code value is also the one-hot bit index.
    typedef enum logic [SRC_W-1:0] {
        SRC_HOCO = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2
    } clk_src_e;

    // Register addresses.
    localparam int ADR_MODE = 0;
    localparam int ADR_STOP = 1;
    localparam int ADR_SEL  = 2;

    // Mode byte field positions.
    localparam int MB_MAIN_EXT  = 0;
    localparam int MB_MAIN_SEL  = 1;
    localparam int MB_MAIN_GAIN = 2;
    localparam int MB_SUB_EXT   = 3;
    localparam int MB_SUB_SEL   = 4;
    localparam int MB_SUB_DRV   = 5;
    localparam int MB_USED      = 7;

    // Stop and select register bit positions.
    localparam int SB_MAIN = 0;
    localparam int SB_SUB  = 1;

    typedef struct packed {
        logic       main_ext;
        logic       main_sel;
        logic       main_gain;
        logic       sub_ext;
        logic       sub_sel;
        logic [1:0] sub_drive;
    } mode_cfg_t;

endpackage

// File: rtl/clksel_regs.sv
// Module: register file of the clock source selector.
// Holds the write-once mode register, the run/stop register and the
// source-select register. Assumes next_src_i is the source that will be
// active after the current edge, so that stopping it can be refused.
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_full,
    input  clk_src_e          next_src_i,
    output mode_cfg_t         mode_o,
    output logic              locked_o,
    output logic              main_stop_o,
    output logic              sub_stop_o,
    output logic              main_req_o,
    output logic              sub_req_o
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(ADR_STOP);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(ADR_SEL);

    mode_cfg_t mode_q;
    logic      locked_q;
    logic      main_stop_q, sub_stop_q;
    logic      main_req_q, sub_req_q;
    logic      mode_wr, stop_wr, sel_wr;
    logic      unused_bits;

    assign unused_bits = ^wr_data[DATA_W-1:MB_USED];

    // Decode which register the current bus cycle targets.
    assign mode_wr = wr_en && (wr_addr == A_MODE) && wr_full && !locked_q;
    assign stop_wr = wr_en && (wr_addr == A_STOP);
    assign sel_wr  = wr_en && (wr_addr == A_SEL);

    // Unpack a written byte into mode fields.
    function automatic mode_cfg_t unpack_mode(input logic [DATA_W-1:0] d);
        mode_cfg_t m;
        m.main_ext  = d[MB_MAIN_EXT];
        m.main_sel  = d[MB_MAIN_SEL];
        m.main_gain = d[MB_MAIN_GAIN];
        m.sub_ext   = d[MB_SUB_EXT];
        m.sub_sel   = d[MB_SUB_SEL];
        m.sub_drive = d[MB_SUB_DRV +: 2];
        return m;
    endfunction

    // Mode register: accepts only the first full-byte write after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            locked_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q   <= unpack_mode(wr_data);
            locked_q <= 1'b1;
        end
    end

    // Stop register: a stop of the running or incoming source is refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_stop_q <= 1'b1;
            sub_stop_q  <= 1'b1;
        end else if (stop_wr) begin
            main_stop_q <= wr_data[SB_MAIN] && (next_src_i != SRC_MAIN);
            sub_stop_q  <= wr_data[SB_SUB]  && (next_src_i != SRC_SUB);
        end
    end

    // Select register: plain request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_req_q <= 1'b0;
            sub_req_q  <= 1'b0;
        end else if (sel_wr) begin
            main_req_q <= wr_data[SB_MAIN];
            sub_req_q  <= wr_data[SB_SUB];
        end
    end

    assign mode_o      = mode_q;
    assign locked_o    = locked_q;
    assign main_stop_o = main_stop_q;
    assign sub_stop_o  = sub_stop_q;
    assign main_req_o  = main_req_q;
    assign sub_req_o   = sub_req_q;

    // R2: once consumed, the mode register never changes again.
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R3: a partial write to the mode register leaves it unconsumed.
    p_partial_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE && !wr_full && !locked_q) |=> !locked_q);

endmodule

// File: rtl/clksel_ready.sv
// Module: readiness evaluation for the requested clock source.
// Picks the target (sub over main over internal) and tells whether it may be
// taken now. Assumes the stabilization flags are already synchronous to clk.
module clksel_ready
    import clksel_pkg::*;
(
    input  logic     main_req_i,
    input  logic     sub_req_i,
    input  logic     main_sel_i,
    input  logic     main_ext_i,
    input  logic     sub_sel_i,
    input  logic     main_stop_i,
    input  logic     sub_stop_i,
    input  logic     main_stable_i,
    input  logic     sub_stable_i,
    output clk_src_e target_o,
    output logic     ready_o
);

    logic [NUM_SRC-1:0] src_ok;

    // Per-source readiness: the external main clock skips stabilization.
    always_comb begin
        src_ok           = '0;
        src_ok[SRC_HOCO] = 1'b1;
        src_ok[SRC_MAIN] = main_sel_i && !main_stop_i && (main_ext_i || main_stable_i);
        src_ok[SRC_SUB]  = sub_sel_i && !sub_stop_i && sub_stable_i;
    end

    // Target priority: sub request first, then main, else internal.
    always_comb begin
        if (sub_req_i)       target_o = SRC_SUB;
        else if (main_req_i) target_o = SRC_MAIN;
        else                 target_o = SRC_HOCO;
    end

    assign ready_o = src_ok[target_o];

endmodule

// File: rtl/clksel_switch.sv
// Module: active-source register and status decode.
// Moves to the target source on the edge where it is ready and holds
// otherwise. Assumes target_i and ready_i are settled before each edge.
module clksel_switch
    import clksel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  clk_src_e           target_i,
    input  logic               ready_i,
    output clk_src_e           active_o,
    output clk_src_e           next_o,
    output logic [NUM_SRC-1:0] onehot_o,
    output logic               pending_o
);

    clk_src_e active_q;

    // Next source: take the target only when it is ready.
    assign next_o = ready_i ? target_i : active_q;

    // Active-source register, internal oscillator after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= SRC_HOCO;
        else        active_q <= next_o;
    end

    // One-hot status decode, one bit per source code.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_onehot
        assign onehot_o[i] = (active_q == SRC_W'(i));
    end

    assign pending_o = (target_i != active_q);
    assign active_o  = active_q;

    // R9: a request for the internal oscillator is served on the next edge.
    p_hoco_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (target_i == SRC_HOCO) |=> (active_q == SRC_HOCO));

endmodule

// File: rtl/clksel_ctrl.sv
// Module: top of the CPU clock source selection controller.
// Connects the register file, the readiness logic and the switch register.
// Assumes a downstream glitch-free mux consumes cpu_src_o / src_onehot_o.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_full_wr,
    input  logic              main_stable_i,
    input  logic              sub_stable_i,
    output logic [1:0]        cpu_src_o,
    output logic [2:0]        src_onehot_o,
    output logic              switch_pending_o,
    output logic              mode_locked_o,
    output logic              main_ext_o,
    output logic              main_osc_sel_o,
    output logic              main_gain_o,
    output logic              sub_ext_o,
    output logic              sub_osc_sel_o,
    output logic [1:0]        sub_drive_o,
    output logic              main_stop_o,
    output logic              sub_stop_o
);

    mode_cfg_t          mode;
    logic               locked, main_stop, sub_stop, main_req, sub_req;
    logic               ready;
    clk_src_e           target, active, next_src;
    logic [NUM_SRC-1:0] onehot;
    logic               pending;

    clksel_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .wr_full     (bus_full_wr),
        .next_src_i  (next_src),
        .mode_o      (mode),
        .locked_o    (locked),
        .main_stop_o (main_stop),
        .sub_stop_o  (sub_stop),
        .main_req_o  (main_req),
        .sub_req_o   (sub_req)
    );

    clksel_ready ready_i (
        .main_req_i    (main_req),
        .sub_req_i     (sub_req),
        .main_sel_i    (mode.main_sel),
        .main_ext_i    (mode.main_ext),
        .sub_sel_i     (mode.sub_sel),
        .main_stop_i   (main_stop),
        .sub_stop_i    (sub_stop),
        .main_stable_i (main_stable_i),
        .sub_stable_i  (sub_stable_i),
        .target_o      (target),
        .ready_o       (ready)
    );

    clksel_switch switch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .target_i  (target),
        .ready_i   (ready),
        .active_o  (active),
        .next_o    (next_src),
        .onehot_o  (onehot),
        .pending_o (pending)
    );

    assign cpu_src_o        = active;
    assign src_onehot_o     = onehot;
    assign switch_pending_o = pending;
    assign mode_locked_o    = locked;
    assign main_ext_o       = mode.main_ext;
    assign main_osc_sel_o   = mode.main_sel;
    assign main_gain_o      = mode.main_gain;
    assign sub_ext_o        = mode.sub_ext;
    assign sub_osc_sel_o    = mode.sub_sel;
    assign sub_drive_o      = mode.sub_drive;
    assign main_stop_o      = main_stop;
    assign sub_stop_o       = sub_stop;

    // R5 R6: entering the main source needs it enabled, running and stable or external.
    p_main_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active == SRC_MAIN && $past(active) != SRC_MAIN) |->
        $past(mode.main_sel && !main_stop && (mode.main_ext || main_stable_i)));

    // R7: entering the sub source always needs its stabilization flag.
    p_sub_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active == SRC_SUB && $past(active) != SRC_SUB) |->
        $past(mode.sub_sel && !sub_stop && sub_stable_i));

    // R10: the oscillator feeding the CPU is never stopped.
    p_main_not_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active == SRC_MAIN) |-> !main_stop);

    p_sub_not_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active == SRC_SUB) |-> !sub_stop);

endmodule

// File: tb/clksel_ctrl_tb_top.sv
`timescale 1ns/1ps
module clksel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_full_wr = 1'b1;
    logic       main_stable_i = 1'b0;
    logic       sub_stable_i = 1'b0;
    logic [1:0] cpu_src_o;
    logic [2:0] src_onehot_o;
    logic       switch_pending_o, mode_locked_o;
    logic       main_ext_o, main_osc_sel_o, main_gain_o, sub_ext_o, sub_osc_sel_o;
    logic [1:0] sub_drive_o;
    logic       main_stop_o, sub_stop_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_full_wr(bus_full_wr),
        .main_stable_i(main_stable_i), .sub_stable_i(sub_stable_i),
        .cpu_src_o(cpu_src_o), .src_onehot_o(src_onehot_o),
        .switch_pending_o(switch_pending_o), .mode_locked_o(mode_locked_o),
        .main_ext_o(main_ext_o), .main_osc_sel_o(main_osc_sel_o),
        .main_gain_o(main_gain_o), .sub_ext_o(sub_ext_o),
        .sub_osc_sel_o(sub_osc_sel_o), .sub_drive_o(sub_drive_o),
        .main_stop_o(main_stop_o), .sub_stop_o(sub_stop_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write cycle; returns at the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic full);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_full_wr = full;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_full_wr = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 src", int'(cpu_src_o), 0);
        chk("R1 R11 onehot", int'(src_onehot_o), 1);
        chk("R1 stops", int'({sub_stop_o, main_stop_o}), 3);
        chk("R1 locked", int'(mode_locked_o), 0);
        chk("R1 pending", int'(switch_pending_o), 0);
        chk("R1 mode", int'({sub_drive_o, sub_osc_sel_o, sub_ext_o, main_gain_o, main_osc_sel_o, main_ext_o}), 0);

        // R3 partial write ignored, not consumed
        wr(2'd0, 8'h03, 1'b0);
        chk("R3 locked", int'(mode_locked_o), 0);
        chk("R3 fields", int'({main_osc_sel_o, main_ext_o}), 0);

        // R4 R2 field layout and write-once: 0x5E -> sel=1 gain=1 subext=1 subsel=1 drive=2
        wr(2'd0, 8'h5E, 1'b1);
        chk("R2 locked", int'(mode_locked_o), 1);
        chk("R4 main_ext", int'(main_ext_o), 0);
        chk("R4 main_sel", int'(main_osc_sel_o), 1);
        chk("R4 main_gain", int'(main_gain_o), 1);
        chk("R4 sub_ext", int'(sub_ext_o), 1);
        chk("R4 sub_sel", int'(sub_osc_sel_o), 1);
        chk("R4 sub_drive", int'(sub_drive_o), 2);
        wr(2'd0, 8'h21, 1'b1);
        chk("R2 second write main_ext", int'(main_ext_o), 0);
        chk("R2 second write drive", int'(sub_drive_o), 2);
        chk("R2 second write sub_sel", int'(sub_osc_sel_o), 1);

        // R5 exact latency of a crystal main switch
        main_stable_i = 1'b1; sub_stable_i = 1'b0;
        wr(2'd1, 8'h00, 1'b1);
        wr(2'd2, 8'h01, 1'b1);
        chk("R5 not yet", int'(cpu_src_o), 0);
        chk("R8 pending during", int'(switch_pending_o), 1);
        @(negedge clk);
        chk("R5 switched", int'(cpu_src_o), 1);
        chk("R11 onehot main", int'(src_onehot_o), 2);
        chk("R5 pending clear", int'(switch_pending_o), 0);

        // R10 stop of active main refused, sub stop applied
        wr(2'd1, 8'h03, 1'b1);
        chk("R10 main stop refused", int'(main_stop_o), 0);
        chk("R10 sub stop applied", int'(sub_stop_o), 1);
        chk("R10 still main", int'(cpu_src_o), 1);

        // R8 R9 sub priority, waits for stabilization
        wr(2'd1, 8'h00, 1'b1);
        wr(2'd2, 8'h03, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 held on main", int'(cpu_src_o), 1);
        chk("R8 R9 pending sub", int'(switch_pending_o), 1);
        sub_stable_i = 1'b1;
        @(negedge clk);
        chk("R7 sub one edge after stable", int'(cpu_src_o), 2);
        chk("R11 onehot sub", int'(src_onehot_o), 4);
        wr(2'd1, 8'h03, 1'b1);
        chk("R10 sub stop refused", int'(sub_stop_o), 0);
        chk("R10 main stop applied", int'(main_stop_o), 1);

        // R9 back to internal with no wait
        wr(2'd2, 8'h00, 1'b1);
        chk("R9 pending internal", int'(switch_pending_o), 1);
        @(negedge clk);
        chk("R9 internal next edge", int'(cpu_src_o), 0);
        chk("R11 onehot internal", int'(src_onehot_o), 1);

        // Sweep: R5 R6 R7 R8 R9 over every mode/stop/stable/request combination
        for (int m = 0; m < 16; m++) begin
            for (int st = 0; st < 4; st++) begin
                for (int sb = 0; sb < 4; sb++) begin
                    for (int sl = 0; sl < 4; sl++) begin
                        logic mext, msel, sext, ssel, mok, sok;
                        int tgt, exp;
                        mext = m[0]; msel = m[1]; sext = m[2]; ssel = m[3];
                        do_reset();
                        wr(2'd0, {1'b0, 2'b01, ssel, sext, 1'b0, msel, mext}, 1'b1);
                        wr(2'd1, 8'(st), 1'b1);
                        main_stable_i = sb[0]; sub_stable_i = sb[1];
                        wr(2'd2, 8'(sl), 1'b1);
                        repeat (3) @(negedge clk);
                        tgt = sl[1] ? 2 : (sl[0] ? 1 : 0);
                        mok = msel && !st[0] && (mext || sb[0]);
                        sok = ssel && !st[1] && sb[1];
                        if (tgt == 0)      exp = 0;
                        else if (tgt == 1) exp = mok ? 1 : 0;
                        else               exp = sok ? 2 : 0;
                        chk("R5 R6 R7 R9 sweep src", int'(cpu_src_o), exp);
                        chk("R8 sweep pending", int'(switch_pending_o), (exp != tgt) ? 1 : 0);
                        chk("R11 sweep onehot", int'(src_onehot_o), 1 << exp);
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule